// File: doc/BRIEF.md
# E-Clock Synchronous Bus Slave Port

This block is the host-facing slave port of a peripheral attached to a 6800-style synchronous processor bus. It oversamples the host's E clock, active-low chip select, read/write line, 11-bit address and 8-bit data bus with the peripheral's own 48 MHz system clock. It turns every selected bus cycle into a single-clock internal strobe toward either a register bank or a RAM. Reads are launched when E rises. Writes are launched when E falls, using the address and data that were present while E was still high.

During a read the port fetches the byte and presents it on its data output with a fixed latency. RAM targets take one clock less than register targets. The output enable stays asserted until the falling edge of E has been seen, and it is withdrawn at once if chip select is released early. The address strobe pin of the bus is constant in this mode and is not brought into the block. The data bus is split into `data_i`, `data_o` and `data_oe_o`, so the pad ring can form the tristate driver.

Top module: `eclk_bus_slave`

## Requirements
- R1: After reset every strobe output and `data_oe_o` are low.
- R2: A rising E with chip select low and read/write high yields exactly one read strobe, one system clock long. It is asserted 3 clocks after the first system clock edge that samples E high, and `mem_addr_o` carries the address present at that time.
- R3: A falling E with chip select low and read/write low yields exactly one write strobe, one clock long. It is asserted 3 clocks after the first edge that samples E low. `mem_addr_o` and `mem_wdata_o` carry the address and data seen while E was still high, even if address, data, select and read/write all change together with the falling E.
- R4: Addresses whose bits [10:5] are all zero (0 to 31) go to the register bank (`reg_rd_o`/`reg_wr_o`). All other addresses go to the RAM (`ram_rd_o`/`ram_wr_o`).
- R5: For a RAM read, `data_oe_o` rises and `data_o` holds the byte returned on `ram_rdata_i` 4 clocks after the first edge that samples E high. For a register read the same happens one clock later, with the byte from `reg_rdata_i`. Before that, `data_oe_o` is low.
- R6: `data_oe_o` stays high while E remains high and through the second clock edge after E falls. It is low 3 clocks after the first edge that samples E low.
- R7: While chip select is high, no strobe is issued for any E activity and `data_oe_o` stays low.
- R8: If chip select goes high after a read strobe but before the data is driven, the read is abandoned and `data_oe_o` never rises. If chip select goes high while data is driven, `data_oe_o` is low 3 clocks later.
- R9: At most one strobe is issued per E period. If read/write changes from high to low during a read cycle, no write follows at the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e_clk_i | input | 1 | Host E clock (asynchronous) |
| cs_n_i | input | 1 | Host chip select, active low |
| rw_i | input | 1 | Host direction, 1 = read, 0 = write |
| addr_i | input | 11 | Host address bus |
| data_i | input | 8 | Data bus input from the pad |
| data_o | output | 8 | Data bus output toward the pad |
| data_oe_o | output | 1 | Pad driver enable for `data_o` |
| ram_rd_o | output | 1 | Single-clock RAM read strobe |
| ram_wr_o | output | 1 | Single-clock RAM write strobe |
| reg_rd_o | output | 1 | Single-clock register read strobe |
| reg_wr_o | output | 1 | Single-clock register write strobe |
| mem_addr_o | output | 11 | Access address, valid with a strobe |
| mem_wdata_o | output | 8 | Write byte, valid with a write strobe |
| ram_rdata_i | input | 8 | RAM read byte, valid in the strobe clock |
| reg_rdata_i | input | 8 | Register read byte, valid in the strobe clock |

## Verification
The checks assume that each E phase lasts at least three system clocks. They also assume that chip select, read/write and the address are settled at least one clock before E rises and stay settled until E falls, so that the oversampled copies line up with the synchronized E. The stimulus changes every input on the inactive clock edge and holds each E phase for four or more clocks. The only inputs it moves at the instant E falls are the ones R3 lets go. It sweeps every address with a write and then a read.

// File: rtl/eclk_slave_pkg.sv
package eclk_slave_pkg;

    // Destination of a host access
    typedef enum logic [0:0] {
        TGT_RAM = 1'b0,
        TGT_REG = 1'b1
    } target_e;

    // Control lines of the host bus, kept together through the synchronizer
    typedef struct packed {
        logic e;
        logic cs_n;
        logic rw;
    } ctrl_bits_t;

    // Idle level: E high and deselected, so no edge is seen on reset exit
    localparam ctrl_bits_t CTRL_IDLE = '{e: 1'b1, cs_n: 1'b1, rw: 1'b1};

endpackage

// File: rtl/eclk_delay_line.sv
module eclk_delay_line #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef logic [WIDTH-1:0] word_t;

    word_t [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/eclk_cycle_ctrl.sv
module eclk_cycle_ctrl
    import eclk_slave_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int REG_DEC_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_bits_t        ctl_i,      // synchronized control lines
    input  logic [ADDR_W-1:0] addr_i,     // address aligned with ctl_i
    input  logic [DATA_W-1:0] data_i,     // data aligned with ctl_i
    output logic              rd_stb_o,
    output logic              wr_stb_o,
    output target_e           tgt_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              fall_o
);

    localparam int DEC_W = ADDR_W - REG_DEC_LSB;

    typedef struct packed {
        ctrl_bits_t        prev;      // control lines one clock earlier
        logic [ADDR_W-1:0] addr_prev;
        logic [DATA_W-1:0] data_prev;
        logic              served;    // a read was issued in this E period
        logic              rd;
        logic              wr;
        target_e           tgt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     rise, fall, rd_req, wr_req;

    function automatic target_e decode(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:REG_DEC_LSB] == DEC_W'(0)) ? TGT_REG : TGT_RAM;
    endfunction

    always_comb begin
        st_d           = st_q;
        st_d.prev      = ctl_i;
        st_d.addr_prev = addr_i;
        st_d.data_prev = data_i;
        st_d.rd        = 1'b0;
        st_d.wr        = 1'b0;

        rise   = ctl_i.e & ~st_q.prev.e;
        fall   = ~ctl_i.e & st_q.prev.e;
        // reads use the sample that first shows E high
        rd_req = rise & ~ctl_i.cs_n & ctl_i.rw;
        // writes use the last sample that still showed E high
        wr_req = fall & ~st_q.prev.cs_n & ~st_q.prev.rw & ~st_q.served;

        if (rise) begin
            st_d.served = rd_req;
        end
        if (rd_req) begin
            st_d.rd   = 1'b1;
            st_d.addr = addr_i;
            st_d.tgt  = decode(addr_i);
        end
        if (wr_req) begin
            st_d.wr    = 1'b1;
            st_d.addr  = st_q.addr_prev;
            st_d.wdata = st_q.data_prev;
            st_d.tgt   = decode(st_q.addr_prev);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.prev      <= CTRL_IDLE;
            st_q.served    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_stb_o = st_q.rd;
    assign wr_stb_o = st_q.wr;
    assign tgt_o    = st_q.tgt;
    assign addr_o   = st_q.addr;
    assign wdata_o  = st_q.wdata;
    assign fall_o   = fall;

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd || st_q.wr) |=> !(st_q.rd || st_q.wr)); // R2
    AST_RD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd |-> $past(!ctl_i.cs_n && ctl_i.rw)); // R7
    AST_WR_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr |-> !st_q.prev.e); // R3
    AST_NO_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd && !st_q.prev.e) |-> 1'b0); // R9

endmodule

// File: rtl/eclk_read_path.sv
module eclk_read_path
    import eclk_slave_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_i,
    input  target_e           tgt_i,
    input  logic              fall_i,     // E fall seen this clock
    input  logic              abort_i,    // synchronized chip select is high
    input  logic [DATA_W-1:0] ram_rdata_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              oe_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              hold_vld;
        logic [DATA_W-1:0] dout;
        logic              oe;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort_i || fall_i) begin
            st_d.hold_vld = 1'b0;
            st_d.oe       = 1'b0;
        end else if (rd_stb_i && tgt_i == TGT_RAM) begin
            st_d.dout = ram_rdata_i;
            st_d.oe   = 1'b1;
        end else if (rd_stb_i) begin
            // register bank takes one extra pipeline stage
            st_d.hold     = reg_rdata_i;
            st_d.hold_vld = 1'b1;
        end else if (st_q.hold_vld) begin
            st_d.dout     = st_q.hold;
            st_d.oe       = 1'b1;
            st_d.hold_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.dout;
    assign oe_o   = st_q.oe;

    AST_OE_DROP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> !st_q.oe); // R6
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!st_q.oe && !st_q.hold_vld)); // R8
    AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> ($past(rd_stb_i && tgt_i == TGT_RAM) || $past(st_q.hold_vld))); // R5

endmodule

// File: rtl/eclk_bus_slave.sv
module eclk_bus_slave
    import eclk_slave_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int REG_DEC_LSB = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_clk_i,
    input  logic              cs_n_i,
    input  logic              rw_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              ram_rd_o,
    output logic              ram_wr_o,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] ram_rdata_i,
    input  logic [DATA_W-1:0] reg_rdata_i
);

    localparam int BUS_W  = ADDR_W + DATA_W;
    localparam int CTRL_W = $bits(ctrl_bits_t);

    ctrl_bits_t        ctl_raw, ctl_sync;
    logic [BUS_W-1:0]  bus_sync;
    logic              rd_stb, wr_stb, fall;
    target_e           tgt;

    assign ctl_raw = '{e: e_clk_i, cs_n: cs_n_i, rw: rw_i};

    eclk_delay_line #(
        .WIDTH  (CTRL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTRL_IDLE)
    ) i_ctrl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (ctl_raw),
        .q_o  (ctl_sync)
    );

    // bus lines are delayed alongside E so that samples stay aligned
    eclk_delay_line #(
        .WIDTH  (BUS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) i_bus_align (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({addr_i, data_i}),
        .q_o  (bus_sync)
    );

    eclk_cycle_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .REG_DEC_LSB(REG_DEC_LSB)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_i   (ctl_sync),
        .addr_i  (bus_sync[BUS_W-1:DATA_W]),
        .data_i  (bus_sync[DATA_W-1:0]),
        .rd_stb_o(rd_stb),
        .wr_stb_o(wr_stb),
        .tgt_o   (tgt),
        .addr_o  (mem_addr_o),
        .wdata_o (mem_wdata_o),
        .fall_o  (fall)
    );

    eclk_read_path #(
        .DATA_W(DATA_W)
    ) i_rdpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb_i   (rd_stb),
        .tgt_i      (tgt),
        .fall_i     (fall),
        .abort_i    (ctl_sync.cs_n),
        .ram_rdata_i(ram_rdata_i),
        .reg_rdata_i(reg_rdata_i),
        .dout_o     (data_o),
        .oe_o       (data_oe_o)
    );

    assign ram_rd_o = rd_stb & (tgt == TGT_RAM);
    assign reg_rd_o = rd_stb & (tgt == TGT_REG);
    assign ram_wr_o = wr_stb & (tgt == TGT_RAM);
    assign reg_wr_o = wr_stb & (tgt == TGT_REG);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd_o, reg_rd_o, ram_wr_o, reg_wr_o})); // R4
    AST_OE_NOT_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr_o || reg_wr_o) |-> !data_oe_o); // R9

endmodule

// File: tb/test_eclk_bus_slave.sv
module test_eclk_bus_slave;

    localparam int CLK_PERIOD = 20;
    localparam int WATCHDOG   = 190000;
    localparam int NADDR      = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        e = 1'b0, cs_n = 1'b1, rw = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  dbus = '0;
    logic [7:0]  data_o, mem_wdata, ram_rdata, reg_rdata;
    logic        data_oe, ram_rd, ram_wr, reg_rd, reg_wr;
    logic [10:0] mem_addr;

    int n_cmp = 0, n_fail = 0, n_rd = 0, n_wr = 0;

    logic [7:0] ram_m  [NADDR];
    logic [7:0] regs_m [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    eclk_bus_slave i_eclk_bus_slave (
        .clk(clk), .rst_n(rst_n), .e_clk_i(e), .cs_n_i(cs_n), .rw_i(rw),
        .addr_i(addr), .data_i(dbus), .data_o(data_o), .data_oe_o(data_oe),
        .ram_rd_o(ram_rd), .ram_wr_o(ram_wr), .reg_rd_o(reg_rd), .reg_wr_o(reg_wr),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .ram_rdata_i(ram_rdata), .reg_rdata_i(reg_rdata)
    );

    assign ram_rdata = ram_m[mem_addr];
    assign reg_rdata = regs_m[mem_addr[4:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NADDR; i++) ram_m[i] <= 8'h00;
            for (int i = 0; i < 32; i++) regs_m[i] <= 8'h00;
        end else begin
            n_rd <= n_rd + int'(ram_rd) + int'(reg_rd);
            n_wr <= n_wr + int'(ram_wr) + int'(reg_wr);
            if (ram_wr) ram_m[mem_addr] <= mem_wdata;
            if (reg_wr) regs_m[mem_addr[4:0]] <= mem_wdata;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 29 + (a >> 4) + 90);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    // full read cycle with latency and enable checks
    task automatic do_read(input int a, input logic [7:0] exp);
        logic is_reg;
        int   r0, w0;
        is_reg = (a < 32);
        @(negedge clk);
        cs_n = 1'b0; rw = 1'b1; addr = 11'(a);
        tick(2);
        r0 = n_rd; w0 = n_wr;
        e = 1'b1;                       // N0
        tick(3);                        // N3: strobe
        chk("R2", "rd strobe ram", 32'(ram_rd), 32'(!is_reg));
        chk("R4", "rd strobe reg", 32'(reg_rd), 32'(is_reg));
        chk("R2", "rd addr", 32'(mem_addr), 32'(a));
        chk("R5", "oe early", 32'(data_oe), 32'(0));
        tick(1);                        // N4
        chk("R2", "strobe width", 32'(ram_rd | reg_rd), 32'(0));
        if (!is_reg) begin
            chk("R5", "ram oe", 32'(data_oe), 32'(1));
            chk("R5", "ram data", 32'(data_o), 32'(exp));
        end else begin
            chk("R5", "reg oe early", 32'(data_oe), 32'(0));
        end
        tick(1);                        // N5
        chk("R5", "oe", 32'(data_oe), 32'(1));
        chk("R5", "data", 32'(data_o), 32'(exp));
        tick(1);
        chk("R6", "oe held", 32'(data_oe), 32'(1));
        e = 1'b0;                       // M0
        tick(2);                        // M2
        chk("R6", "oe after fall", 32'(data_oe), 32'(1));
        tick(1);                        // M3
        chk("R6", "oe release", 32'(data_oe), 32'(0));
        chk("R9", "one read", 32'(n_rd - r0), 32'(1));
        chk("R9", "no write", 32'(n_wr - w0), 32'(0));
        cs_n = 1'b1;
        tick(1);
    endtask

    // write cycle; every bus line lets go together with the falling E
    task automatic do_write(input int a, input logic [7:0] d);
        logic is_reg;
        int   w0;
        is_reg = (a < 32);
        @(negedge clk);
        cs_n = 1'b0; rw = 1'b0; addr = 11'(a); dbus = d;
        tick(2);
        w0 = n_wr;
        e = 1'b1;
        tick(4);
        chk("R3", "no early strobe", 32'(ram_wr | reg_wr | ram_rd | reg_rd), 32'(0));
        e = 1'b0;                       // M0
        addr = ~addr; dbus = ~d; cs_n = 1'b1; rw = 1'b1;
        tick(2);
        chk("R3", "wr not yet", 32'(ram_wr | reg_wr), 32'(0));
        tick(1);                        // M3
        chk("R3", "wr ram", 32'(ram_wr), 32'(!is_reg));
        chk("R4", "wr reg", 32'(reg_wr), 32'(is_reg));
        chk("R3", "wr addr", 32'(mem_addr), 32'(a));
        chk("R3", "wr data", 32'(mem_wdata), 32'(d));
        tick(1);
        chk("R3", "wr width", 32'(ram_wr | reg_wr), 32'(0));
        chk("R3", "one write", 32'(n_wr - w0), 32'(1));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL all requirements watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        int r0, w0;
        tick(4);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk("R1", "oe", 32'(data_oe), 32'(0));
        chk("R1", "strobes", 32'({ram_rd, ram_wr, reg_rd, reg_wr}), 32'(0));
        chk("R1", "count", 32'(n_rd + n_wr), 32'(0));

        // R7 deselected E activity
        r0 = n_rd; w0 = n_wr;
        for (int k = 0; k < 40; k++) begin
            rw = k[1]; addr = 11'(k * 51);
            e = 1'b1; tick(4);
            chk("R7", "oe deselected", 32'(data_oe), 32'(0));
            e = 1'b0; tick(4);
        end
        chk("R7", "no reads", 32'(n_rd - r0), 32'(0));
        chk("R7", "no writes", 32'(n_wr - w0), 32'(0));

        // R3 R4 sweep: write every address, then read every address
        for (int a = 0; a < NADDR; a++) do_write(a, pat(a));
        for (int a = 0; a < NADDR; a++) do_read(a, pat(a));

        // R9 direction changes to write during a read period
        r0 = n_rd; w0 = n_wr;
        cs_n = 1'b0; rw = 1'b1; addr = 11'd700; tick(2);
        e = 1'b1; tick(4);
        rw = 1'b0; tick(3);
        e = 1'b0; tick(5);
        chk("R9", "read once", 32'(n_rd - r0), 32'(1));
        chk("R9", "no write", 32'(n_wr - w0), 32'(0));
        chk("R9", "ram unchanged", 32'(ram_m[700]), 32'(pat(700)));
        cs_n = 1'b1; rw = 1'b1; tick(2);

        // R8 select dropped before data is driven
        r0 = n_rd;
        cs_n = 1'b0; addr = 11'd900; tick(2);
        e = 1'b1;                       // N0
        tick(1); cs_n = 1'b1;           // N1
        for (int k = 0; k < 5; k++) begin
            tick(1);
            chk("R8", "abandoned oe", 32'(data_oe), 32'(0));
        end
        chk("R8", "strobe issued", 32'(n_rd - r0), 32'(1));
        e = 1'b0; tick(4);

        // R8 select dropped while data is driven
        cs_n = 1'b0; addr = 11'd1500; tick(2);
        e = 1'b1; tick(5);
        chk("R8", "oe before drop", 32'(data_oe), 32'(1));
        cs_n = 1'b1; tick(3);
        chk("R8", "oe after drop", 32'(data_oe), 32'(0));
        e = 1'b0; tick(4);

        summary();
        $finish;
    end

endmodule